// File: doc/BRIEF.md
# GPIO Port Controller with Level-Sense Detection

This block controls a bank of general-purpose pins, up to 32 of them, from a single register port. Software sets the driven value and the drive direction of each pin either by writing whole words or through set and clear alias addresses that change only the bits written as one. Each pin has a configuration word. That word holds a copy of the pin's direction bit, an input-buffer enable, and a two-bit sense field. The input register samples the pad levels through the input-buffer enable mask, so a pin whose buffer is disconnected reads as 0.

Each pin with sensing enabled produces a detect bit. A high-sensed pin detects a 1 and a low-sensed pin detects a 0. A sticky latch register collects these detect bits. The port has one detect output. In direct mode it is the OR of the live per-pin detects. In latched mode it is the OR of the latch register. The port also gives a single-cycle event pulse when the detect output rises. In latched mode it gives the same pulse when software clears the latch and bits remain set afterwards.

Peripherals can take over the direction of any pin, and separately the driven value of any pin. Every register write takes effect on the pads, the input register and the detect logic at the same clock edge that stores the write.

Top module: `gpsn_port`

## Requirements
- R1: After synchronous reset, every register reads 0. All pins are inputs with the input buffer disconnected and sense disabled. `pad_oe`, `pad_out`, `detect` and `detect_evt` are all 0.
- R2: The output value register is at address 0. Writing address 1 (set alias) ORs the written bits into it. A read of address 1 returns the output value register.
- R3: Writing address 2 (clear alias) clears the written bits of the output value register. A read of address 2 returns 0.
- R4: The direction register is at address 4, with a set alias at 5 and a clear alias at 6. Reading 5 returns the direction register and reading 6 returns 0. A pin whose direction bit is 1 drives: `pad_oe` is 1 and `pad_out` carries its output bit. A pin that does not drive has `pad_out` at 0.
- R5: The configuration word of pin n is at address 16+n. Bit 0 is direction, bit 1 is input-buffer enable, and bits 3:2 are sense. Bit 0 always mirrors bit n of the direction register, whichever of the two was written.
- R6: The input register at address 3 equals `pad_in` ANDed with the input-buffer enables. A disconnected pin reads 0.
- R7: When `ovr_dir_en[n]` is 1, `ovr_dir_val[n]` replaces the direction bit of pin n. When `ovr_out_en[n]` is 1, `ovr_out_val[n]` replaces the output bit of pin n. The register contents are unchanged.
- R8: Sense code 2'b10 detects input 1 and 2'b11 detects input 0. Codes 2'b00 and 2'b01 disable detection. With the mode register (address 8, bit 0) at 0, `detect` is the OR of the live per-pin detects.
- R9: The latch register at address 7 accumulates per-pin detects and is write-one-to-clear. A bit whose detect is still active stays set after it is cleared.
- R10: With mode bit 1, `detect` is the OR of the latch register and stays high after the inputs return to idle.
- R11: `detect_evt` pulses for exactly one cycle when `detect` rises.
- R12: In latched mode, a latch write with a nonzero value that leaves latch bits set pulses `detect_evt`. The same write in direct mode, or a zero write, gives no pulse.
- R13: A register write or a pad change is visible on `pad_oe`/`pad_out`, on the input register and on `detect` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered one cycle after the read request |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Driven pad values |
| pad_oe | output | NPINS | Pad output enables |
| ovr_dir_en | input | NPINS | Peripheral direction override enable |
| ovr_dir_val | input | NPINS | Peripheral direction value |
| ovr_out_en | input | NPINS | Peripheral output override enable |
| ovr_out_val | input | NPINS | Peripheral output value |
| detect | output | 1 | Port detect signal |
| detect_evt | output | 1 | One-cycle detect event pulse |

## Verification
The bench first checks that a configuration write of the direction bit changes the direction register, and that the reverse also holds. A design that kept two separate copies would read stale values at one of the two addresses. It also checks that a cleared latch bit stays set while its pin still detects. A plain clear-on-write latch would drop that bit and lose the pending detect in latched mode. The re-raise pulse is tested in latched mode with a nonzero write, and a design that pulsed only on rising edges would miss it. The same write is also tested in direct mode and with zero data, and a design that pulsed on every latch write would fire there. Finally, overrides are applied to pins the direction register leaves undriven, and reserved sense code 2'b01 is checked, which catches a mux with the select inverted and a decoder that treats any nonzero code as active.

// File: rtl/gpsn_pkg.sv
package gpsn_pkg;
  localparam int A_OUT    = 0;
  localparam int A_OUTSET = 1;
  localparam int A_OUTCLR = 2;
  localparam int A_IN     = 3;
  localparam int A_DIR    = 4;
  localparam int A_DIRSET = 5;
  localparam int A_DIRCLR = 6;
  localparam int A_LATCH  = 7;
  localparam int A_MODE   = 8;
  localparam int CFG_BASE = 16;

  typedef enum logic [1:0] {
    SNS_OFF  = 2'b00,
    SNS_RSV  = 2'b01,
    SNS_HIGH = 2'b10,
    SNS_LOW  = 2'b11
  } sense_e;

  typedef struct packed {
    logic en;
    logic inv;
  } sense_ctl_t;

  function automatic sense_ctl_t decode_sense(input logic [1:0] code);
    sense_ctl_t r;
    case (sense_e'(code))
      SNS_HIGH: r = '{en: 1'b1, inv: 1'b0};
      SNS_LOW:  r = '{en: 1'b1, inv: 1'b1};
      default:  r = '{en: 1'b0, inv: 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpsn_regfile.sv
module gpsn_regfile
  import gpsn_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NPINS-1:0]  in_q,
  input  logic [NPINS-1:0]  latch_q,
  output logic [DATA_W-1:0] rd_data,
  output logic [NPINS-1:0]  dir_nxt,
  output logic [NPINS-1:0]  out_nxt,
  output logic [NPINS-1:0]  inen_nxt,
  output logic [NPINS-1:0]  inen_cur,
  output logic [NPINS-1:0]  sen_nxt,
  output logic [NPINS-1:0]  sinv_nxt,
  output logic              mode_nxt,
  output logic              mode_cur,
  output logic              latch_wr,
  output logic              latch_nz,
  output logic [NPINS-1:0]  latch_clr
);
  logic              wr_en, rd_en;
  logic [NPINS-1:0]  wdat;
  logic [NPINS-1:0]  out_q, dir_q, dir_base, inen_q;
  logic              mode_q;
  logic [1:0]        sns_q [NPINS];
  logic [NPINS-1:0]  cfg_hit;
  logic [DATA_W-1:0] cfg_rd;

  assign wr_en     = req_valid & req_write;
  assign rd_en     = req_valid & ~req_write;
  assign wdat      = req_wdata[NPINS-1:0];
  assign latch_wr  = wr_en && (req_addr == ADDR_W'(A_LATCH));
  assign latch_clr = wdat;
  assign latch_nz  = |req_wdata;
  assign inen_cur  = inen_q;
  assign mode_cur  = mode_q;

  always_comb begin
    out_nxt  = out_q;
    dir_base = dir_q;
    mode_nxt = mode_q;
    if (wr_en) begin
      case (req_addr)
        ADDR_W'(A_OUT):    out_nxt  = wdat;
        ADDR_W'(A_OUTSET): out_nxt  = out_q | wdat;
        ADDR_W'(A_OUTCLR): out_nxt  = out_q & ~wdat;
        ADDR_W'(A_DIR):    dir_base = wdat;
        ADDR_W'(A_DIRSET): dir_base = dir_q | wdat;
        ADDR_W'(A_DIRCLR): dir_base = dir_q & ~wdat;
        ADDR_W'(A_MODE):   mode_nxt = req_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] sns_n;
    sense_ctl_t ctl;
    assign cfg_hit[i]  = wr_en && (req_addr == ADDR_W'(CFG_BASE + i));
    assign dir_nxt[i]  = cfg_hit[i] ? req_wdata[0] : dir_base[i];
    assign inen_nxt[i] = cfg_hit[i] ? req_wdata[1] : inen_q[i];
    assign sns_n       = cfg_hit[i] ? req_wdata[3:2] : sns_q[i];
    assign ctl         = decode_sense(sns_n);
    assign sen_nxt[i]  = ctl.en;
    assign sinv_nxt[i] = ctl.inv;

    always_ff @(posedge clk) begin
      if (rst) begin
        inen_q[i] <= 1'b0;
        sns_q[i]  <= 2'b00;
      end else begin
        inen_q[i] <= inen_nxt[i];
        sns_q[i]  <= sns_n;
      end
    end

    // R5: a configuration write sets the port direction bit
    assert_cfg_dir_R5: assert property (@(posedge clk) disable iff (rst)
      cfg_hit[i] |=> (dir_q[i] == $past(req_wdata[0])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      out_q  <= out_nxt;
      dir_q  <= dir_nxt;
      mode_q <= mode_nxt;
    end
  end

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (req_addr == ADDR_W'(CFG_BASE + i))
        cfg_rd[3:0] = {sns_q[i], inen_q[i], dir_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (req_addr)
        ADDR_W'(A_OUT),
        ADDR_W'(A_OUTSET): rd_data <= DATA_W'(out_q);
        ADDR_W'(A_OUTCLR): rd_data <= '0;
        ADDR_W'(A_IN):     rd_data <= DATA_W'(in_q);
        ADDR_W'(A_DIR),
        ADDR_W'(A_DIRSET): rd_data <= DATA_W'(dir_q);
        ADDR_W'(A_DIRCLR): rd_data <= '0;
        ADDR_W'(A_LATCH):  rd_data <= DATA_W'(latch_q);
        ADDR_W'(A_MODE):   rd_data <= DATA_W'(mode_q);
        default:           rd_data <= cfg_rd;
      endcase
    end
  end

  assert_outclr_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && req_addr == ADDR_W'(A_OUTCLR)) |=> (rd_data == '0));

  assert_outset_merges_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && req_addr == ADDR_W'(A_OUTSET)) |=> ((out_q & $past(wdat)) == $past(wdat)));
endmodule

// File: rtl/gpsn_padmux.sv
module gpsn_padmux #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_nxt,
  input  logic [NPINS-1:0] out_nxt,
  input  logic [NPINS-1:0] inen_nxt,
  input  logic [NPINS-1:0] ovr_dir_en,
  input  logic [NPINS-1:0] ovr_dir_val,
  input  logic [NPINS-1:0] ovr_out_en,
  input  logic [NPINS-1:0] ovr_out_val,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] in_q,
  output logic [NPINS-1:0] in_nxt
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic eff_dir, eff_out;
    assign eff_dir   = ovr_dir_en[i] ? ovr_dir_val[i] : dir_nxt[i];
    assign eff_out   = ovr_out_en[i] ? ovr_out_val[i] : out_nxt[i];
    assign in_nxt[i] = pad_in[i] & inen_nxt[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
        in_q[i]    <= 1'b0;
      end else begin
        pad_oe[i]  <= eff_dir;
        pad_out[i] <= eff_dir & eff_out;
        in_q[i]    <= in_nxt[i];
      end
    end
  end

  assert_dir_override_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_dir_en != '0) |=> ((pad_oe & $past(ovr_dir_en)) == $past(ovr_dir_val & ovr_dir_en)));
endmodule

// File: rtl/gpsn_sense.sv
module gpsn_sense #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] in_nxt,
  input  logic [NPINS-1:0] sen_nxt,
  input  logic [NPINS-1:0] sinv_nxt,
  input  logic             mode_nxt,
  input  logic             mode_cur,
  input  logic             latch_wr,
  input  logic             latch_nz,
  input  logic [NPINS-1:0] latch_clr,
  output logic [NPINS-1:0] latch_q,
  output logic             detect,
  output logic             detect_evt
);
  logic [NPINS-1:0] det_nxt, det_q, latch_nxt, clr_mask;
  logic             any_nxt, rearm;

  assign det_nxt   = (in_nxt ^ sinv_nxt) & sen_nxt;
  assign clr_mask  = latch_wr ? latch_clr : '0;
  assign latch_nxt = (latch_q & ~clr_mask) | det_nxt;
  assign any_nxt   = mode_nxt ? (|latch_nxt) : (|det_nxt);
  assign rearm     = latch_wr && latch_nz && mode_nxt && (latch_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q      <= '0;
      latch_q    <= '0;
      detect     <= 1'b0;
      detect_evt <= 1'b0;
    end else begin
      det_q      <= det_nxt;
      latch_q    <= latch_nxt;
      detect     <= any_nxt;
      detect_evt <= (any_nxt & ~detect) | rearm;
    end
  end

  assert_latch_holds_active_R9: assert property (@(posedge clk) disable iff (rst)
    ((latch_q & det_q) == det_q));

  assert_latched_detect_R10: assert property (@(posedge clk) disable iff (rst)
    mode_cur |-> (detect == (|latch_q)));

  assert_rise_gives_event_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> detect_evt);
endmodule

// File: rtl/gpsn_port.sv
module gpsn_port
  import gpsn_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(CFG_BASE + NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  ovr_dir_en,
  input  logic [NPINS-1:0]  ovr_dir_val,
  input  logic [NPINS-1:0]  ovr_out_en,
  input  logic [NPINS-1:0]  ovr_out_val,
  output logic              detect,
  output logic              detect_evt
);
  logic [NPINS-1:0] in_q, in_nxt, latch_q, latch_clr;
  logic [NPINS-1:0] dir_nxt, out_nxt, inen_nxt, inen_cur, sen_nxt, sinv_nxt;
  logic             mode_nxt, mode_cur, latch_wr, latch_nz;

  gpsn_regfile #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .in_q(in_q), .latch_q(latch_q),
    .rd_data(rd_data), .dir_nxt(dir_nxt), .out_nxt(out_nxt), .inen_nxt(inen_nxt),
    .inen_cur(inen_cur), .sen_nxt(sen_nxt), .sinv_nxt(sinv_nxt),
    .mode_nxt(mode_nxt), .mode_cur(mode_cur), .latch_wr(latch_wr),
    .latch_nz(latch_nz), .latch_clr(latch_clr)
  );

  gpsn_padmux #(.NPINS(NPINS)) u_pads (
    .clk(clk), .rst(rst), .dir_nxt(dir_nxt), .out_nxt(out_nxt), .inen_nxt(inen_nxt),
    .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val), .ovr_out_en(ovr_out_en),
    .ovr_out_val(ovr_out_val), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .in_q(in_q), .in_nxt(in_nxt)
  );

  gpsn_sense #(.NPINS(NPINS)) u_sense (
    .clk(clk), .rst(rst), .in_nxt(in_nxt), .sen_nxt(sen_nxt), .sinv_nxt(sinv_nxt),
    .mode_nxt(mode_nxt), .mode_cur(mode_cur), .latch_wr(latch_wr),
    .latch_nz(latch_nz), .latch_clr(latch_clr), .latch_q(latch_q),
    .detect(detect), .detect_evt(detect_evt)
  );

  // R6: disconnected inputs never show a 1 in the input register
  assert_input_masked_R6: assert property (@(posedge clk) disable iff (rst)
    ((in_q & ~inen_cur) == '0));
endmodule

// File: tb/sim_gpsn_port.sv
module sim_gpsn_port;
  localparam int NP = 8;
  localparam int DW = 32;
  localparam int AW = $clog2(16 + NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] pad_in = '1;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP-1:0] ovr_dir_en = '0, ovr_dir_val = '0, ovr_out_en = '0, ovr_out_val = '0;
  logic          detect, detect_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rd_pend = 1'b0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  gpsn_port #(.NPINS(NP), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
    .ovr_out_en(ovr_out_en), .ovr_out_val(ovr_out_val),
    .detect(detect), .detect_evt(detect_evt)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read result is due
  always @(posedge clk) rd_pend <= req_valid && !req_write && !rst;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pads(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", DW'(pad_oe), 0);
    chk("R1 pad_out", DW'(pad_out), 0);
    chk("R1 detect", DW'(detect), 0);
    chk("R1 evt", DW'(detect_evt), 0);
    rd(0, 0, "R1 out reg");
    rd(4, 0, "R1 dir reg");
    rd(3, 0, "R6 disconnected reads 0");
    rd(7, 0, "R1 latch");
    rd(16, 0, "R1 cfg0");

    // R2/R3 output register and aliases
    wr(0, 32'h05);
    rd(0, 32'h05, "R2 out write");
    chk("R4 undriven pad_out", DW'(pad_out), 0);
    wr(1, 32'h30);
    rd(0, 32'h35, "R2 outset merge");
    rd(1, 32'h35, "R2 outset readback");
    wr(2, 32'h11);
    rd(0, 32'h24, "R3 outclr");
    rd(2, 32'h00, "R3 outclr reads 0");

    // R4/R13 direction and pads
    wr(4, 32'h0F);
    chk("R13 pad_oe after dir write", DW'(pad_oe), 32'h0F);
    chk("R4 pad_out", DW'(pad_out), 32'h04);
    wr(5, 32'hF0);
    rd(4, 32'hFF, "R4 dirset");
    wr(6, 32'h81);
    rd(4, 32'h7E, "R4 dirclr");
    rd(5, 32'h7E, "R4 dirset readback");
    rd(6, 32'h00, "R4 dirclr reads 0");
    rd(17, 32'h1, "R5 cfg1 mirrors dir");
    rd(16, 32'h0, "R5 cfg0 mirrors dir");
    wr(23, 32'h1);
    rd(4, 32'hFE, "R5 cfg7 sets dir");
    wr(17, 32'h0);
    rd(4, 32'hFC, "R5 cfg1 clears dir");
    chk("R5 pad_oe", DW'(pad_oe), 32'hFC);

    // R7 overrides
    @(negedge clk);
    ovr_dir_en = 8'h03; ovr_dir_val = 8'h01; ovr_out_en = 8'h01; ovr_out_val = 8'h01;
    @(negedge clk);
    chk("R7 override oe", DW'(pad_oe), 32'hFD);
    chk("R7 override out", DW'(pad_out), 32'h25);
    rd(4, 32'hFC, "R7 dir reg unchanged");
    @(negedge clk);
    ovr_dir_en = '0; ovr_out_en = '0;
    @(negedge clk);
    chk("R7 override released", DW'(pad_oe), 32'hFC);

    // R6 input masking
    wr(4, 32'h00);
    wr(16, 32'h2);
    wr(19, 32'h2);
    pads(8'h0B);
    rd(3, 32'h09, "R6 input masked");
    pads(8'h02);
    rd(3, 32'h00, "R6 input low");

    // R8/R9/R11 direct mode
    wr(18, 32'hA);
    chk("R8 high sense idle", DW'(detect), 0);
    pads(8'h04);
    chk("R8 high sense detect", DW'(detect), 1);
    chk("R11 rise pulse", DW'(detect_evt), 1);
    idle();
    chk("R11 pulse one cycle", DW'(detect_evt), 0);
    rd(7, 32'h04, "R9 latch accumulates");
    pads(8'h00);
    chk("R8 direct follows input", DW'(detect), 0);
    rd(7, 32'h04, "R9 latch sticky");
    wr(7, 32'h04);
    rd(7, 32'h00, "R9 latch w1c");
    wr(20, 32'hE);
    chk("R8 low sense detect", DW'(detect), 1);
    chk("R13 cfg write evt", DW'(detect_evt), 1);
    wr(20, 32'h6);
    chk("R8 reserved code disabled", DW'(detect), 0);
    rd(7, 32'h10, "R9 latch low-sense bit");
    wr(7, 32'hFF);
    rd(7, 32'h00, "R9 latch cleared");

    // R10/R12 latched mode
    wr(8, 32'h1);
    chk("R10 latched idle", DW'(detect), 0);
    pads(8'h04);
    chk("R10 latched detect", DW'(detect), 1);
    chk("R11 latched rise", DW'(detect_evt), 1);
    pads(8'h00);
    chk("R10 stays high", DW'(detect), 1);
    chk("R11 no pulse while high", DW'(detect_evt), 0);
    wr(7, 32'h04);
    chk("R10 clear drops detect", DW'(detect), 0);
    chk("R12 no pulse when empty", DW'(detect_evt), 0);
    pads(8'h04);
    idle();
    wr(7, 32'h04);
    chk("R12 rearm pulse", DW'(detect_evt), 1);
    chk("R9 active bit kept", DW'(detect), 1);
    rd(7, 32'h04, "R9 active bit survives clear");
    wr(7, 32'h01);
    chk("R12 rearm other bit", DW'(detect_evt), 1);
    wr(7, 32'h00);
    chk("R12 zero write no pulse", DW'(detect_evt), 0);
    wr(8, 32'h0);
    chk("R8 direct mode live", DW'(detect), 1);
    chk("R11 no rise on mode change", DW'(detect_evt), 0);
    wr(7, 32'h04);
    chk("R12 direct mode no rearm", DW'(detect_evt), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule